// File: doc/BRIEF.md
# Signed Binary to Packed Decimal Converter

This block turns a signed 64-bit integer into an 80-bit packed-decimal value held as a 64-bit low word and a 16-bit high word. It is meant to sit after a float-to-integer rounding step. It takes the rounded integer together with that step's exception flags, and it returns the decimal result with the flags the conversion leaves behind.

The magnitude of the input is converted one binary bit per clock. Each step shifts the value left and first adds three to any decimal digit that is 5 or more. The sign is kept apart and placed in the top bit of the high word. The decimal field holds eighteen digits. A magnitude above eighteen nines, or an invalid flag already raised upstream, replaces the result with the fixed decimal indefinite pattern.

A one-cycle `start` launches a conversion. `done` pulses once, a fixed number of cycles later. The result registers change only on that pulse.

Top module: `bcd_pack_conv`

## Requirements
- R1: While `rst_n` is low, and until the first conversion ends, `done`, `invalid`, `bcd_lo`, `bcd_hi` and `exc_out` are all zero.
- R2: `start` is accepted when high at a rising edge while no conversion is running. `done` is then high for exactly one cycle, 64 rising edges later.
- R3: For a valid result, `bcd_lo[4k+3:4k]` holds decimal digit k for k = 0..15, where digit 0 is the least significant. `bcd_hi[3:0]` holds digit 16, `bcd_hi[7:4]` holds digit 17, and `bcd_hi[14:8]` is zero.
- R4: For a valid result, `bcd_hi[15]` is 1 exactly when the input is negative, and the digits encode the absolute value of the input.
- R5: When the input magnitude is greater than 999999999999999999, `invalid` is 1, `bcd_hi` = 16'hFFFF and `bcd_lo` = 64'hC000000000000000. `exc_out` is then 6'b000001: only bit 0 (invalid) survives and all other incoming flags are dropped.
- R6: When `exc_in[0]` (upstream invalid) is 1, the output is the same indefinite pattern with `invalid` = 1, and `exc_out` equals `exc_in`.
- R7: The input 64'h8000000000000000 is reported invalid with the indefinite pattern.
- R8: For a valid result, `invalid` is 0 and `exc_out` equals the `exc_in` captured at start.
- R9: `bcd_lo`, `bcd_hi`, `invalid` and `exc_out` keep their values in every cycle that `done` is low.
- R10: A `start` that arrives while a conversion is running is ignored. The running conversion completes on its own schedule, and its result comes from its own operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion of `bin_in` |
| bin_in | input | 64 | Two's-complement integer to convert |
| exc_in | input | 6 | Exception flags from the rounding step; bit 0 is invalid |
| done | output | 1 | One-cycle pulse when the result is updated |
| bcd_lo | output | 64 | Decimal digits 0 to 15 |
| bcd_hi | output | 16 | Sign in bit 15, digits 17 and 16 in bits 7:0 |
| invalid | output | 1 | Result is the indefinite pattern |
| exc_out | output | 6 | Exception flags after the range check |

## Verification
The hardest cases to reach from the ports are the values that sit exactly on the eighteen-digit boundary on either side of zero, and a second `start` that arrives partway through a conversion. The stimulus drives both signs of eighteen nines and of ten to the eighteenth, the most negative integer, and a second start some cycles after the first, carrying a different operand and different flags. A behavioural model in the bench computes each result by repeated division by ten and is compared with the outputs on every clock. That comparison exposes a second start that leaks into the result, a shifted done pulse, and output registers that change outside the done cycle.

// File: rtl/bcd_pack_conv.sv
module bcd_pack_conv #(
  parameter int DATA_W = 64,
  parameter int DIGITS = 18,
  parameter int EXC_W  = 6,
  parameter logic [63:0] LIMIT = 64'd999999999999999999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] bin_in,
  input  logic [EXC_W-1:0]  exc_in,
  output logic              done,
  output logic [63:0]       bcd_lo,
  output logic [15:0]       bcd_hi,
  output logic              invalid,
  output logic [EXC_W-1:0]  exc_out
);
  localparam int BCD_W = DIGITS * 4;
  localparam int HI_W  = BCD_W - 64;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [BCD_W-1:0]  acc;
  logic [BCD_W-1:0]  adj;
  logic [BCD_W-1:0]  acc_nx;
  logic              neg_r, bad_r;
  logic [EXC_W-1:0]  exc_r;

  wire              in_neg  = bin_in[DATA_W-1];
  wire [DATA_W-1:0] in_mag  = in_neg ? (~bin_in + 1'b1) : bin_in;
  wire              too_big = in_mag > LIMIT;
  wire              accept  = start && !busy;
  wire              last    = busy && (cnt == CNT_W'(DATA_W - 1));

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    wire [3:0] nib = acc[g*4 +: 4];
    assign adj[g*4 +: 4] = (nib >= 4'd5) ? nib + 4'd3 : nib;
  end

  assign acc_nx = {adj[BCD_W-2:0], shreg[DATA_W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
      acc   <= '0;
      neg_r <= 1'b0;
      bad_r <= 1'b0;
      exc_r <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= '0;
      shreg <= in_mag;
      acc   <= '0;
      neg_r <= in_neg;
      bad_r <= exc_in[0] || too_big;
      exc_r <= exc_in[0] ? exc_in : (too_big ? EXC_W'(1) : exc_in);
    end else if (busy) begin
      shreg <= shreg << 1;
      acc   <= acc_nx;
      cnt   <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      bcd_lo  <= '0;
      bcd_hi  <= '0;
      invalid <= 1'b0;
      exc_out <= '0;
    end else begin
      done <= last;
      if (last) begin
        invalid <= bad_r;
        exc_out <= exc_r;
        if (bad_r) begin
          bcd_hi <= 16'hFFFF;
          bcd_lo <= 64'hC000_0000_0000_0000;
        end else begin
          bcd_hi <= {neg_r, (15 - HI_W)'(0), acc_nx[BCD_W-1:64]};
          bcd_lo <= acc_nx[63:0];
        end
      end
    end
  end

  logic [CNT_W:0] chk_age;
  logic           chk_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_age <= '0;
      chk_run <= 1'b0;
    end else if (start && !chk_run) begin
      chk_age <= '0;
      chk_run <= 1'b1;
    end else if (chk_run) begin
      chk_age <= chk_age + 1'b1;
      if (chk_age == (CNT_W+1)'(DATA_W - 1)) chk_run <= 1'b0;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(chk_run) && !chk_run);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_indefinite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> (bcd_hi == 16'hFFFF && bcd_lo == 64'hC000_0000_0000_0000 && exc_out[0]));
  p_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !invalid) |-> (bcd_hi[14:8] == 7'd0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(bcd_lo) && $stable(bcd_hi) && $stable(invalid) && $stable(exc_out)));
  p_valid_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !invalid) |-> !exc_out[0]);
endmodule

// File: tb/bcd_pack_conv_tb.sv
module bcd_pack_conv_tb;
  localparam int CLK_P = 10;
  localparam int LAT = 64;
  localparam logic [63:0] LIM = 64'd999999999999999999;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] bin_in = '0;
  logic [5:0] exc_in = '0;
  logic done, invalid;
  logic [63:0] bcd_lo;
  logic [15:0] bcd_hi;
  logic [5:0] exc_out;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";

  bcd_pack_conv u_dut (.clk(clk), .rst_n(rst_n), .start(start), .bin_in(bin_in),
    .exc_in(exc_in), .done(done), .bcd_lo(bcd_lo), .bcd_hi(bcd_hi),
    .invalid(invalid), .exc_out(exc_out));

  always #(CLK_P/2) clk = ~clk;

  logic m_busy = 0, m_done = 0, m_inv = 0;
  int m_cnt = 0;
  logic [63:0] m_lo = 0, p_lo;
  logic [15:0] m_hi = 0, p_hi;
  logic [5:0] m_exc = 0, p_exc;
  logic p_inv;

  task automatic expect_of(input logic [63:0] x, input logic [5:0] e,
      output logic [63:0] lo, output logic [15:0] hi, output logic inv, output logic [5:0] eo);
    logic [63:0] mag;
    mag = x[63] ? (~x + 64'd1) : x;
    if (e[0] || mag > LIM) begin
      lo = 64'hC000000000000000; hi = 16'hFFFF; inv = 1'b1;
      eo = e[0] ? e : 6'b000001;
    end else begin
      lo = '0; hi = {x[63], 15'd0}; inv = 1'b0; eo = e;
      for (int k = 0; k < 18; k++) begin
        if (k < 16) lo[k*4 +: 4] = 4'(mag % 64'd10);
        else hi[(k-16)*4 +: 4] = 4'(mag % 64'd10);
        mag = mag / 64'd10;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_lo = 0; m_hi = 0; m_inv = 0; m_exc = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LAT) begin
          m_busy = 0; m_done = 1; m_lo = p_lo; m_hi = p_hi; m_inv = p_inv; m_exc = p_exc;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
        expect_of(bin_in, exc_in, p_lo, p_hi, p_inv, p_exc);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (done !== m_done || bcd_lo !== m_lo || bcd_hi !== m_hi || invalid !== m_inv || exc_out !== m_exc) begin
      errors++;
      $display("FAIL %s: actual done=%b hi=%h lo=%h inv=%b exc=%b expected done=%b hi=%h lo=%h inv=%b exc=%b",
        cur_req, done, bcd_hi, bcd_lo, invalid, exc_out, m_done, m_hi, m_lo, m_inv, m_exc);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input logic [63:0] x, input logic [5:0] e, input string tag);
    @(negedge clk);
    cur_req = tag; start = 1'b1; bin_in = x; exc_in = e;
    @(negedge clk);
    start = 1'b0; bin_in = ~x; exc_in = ~e;
    repeat (LAT + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(64'd0, 6'd0, "R3");
    run(64'd1234567890123456, 6'd0, "R3");
    run(64'd999999999999999999, 6'd0, "R3");
    run(-64'sd1, 6'd0, "R4");
    run(-64'sd999999999999999999, 6'd0, "R4");
    run(64'd1000000000000000000, 6'b100110, "R5");
    run(-64'sd1000000000000000000, 6'b000100, "R5");
    run(64'h7FFFFFFFFFFFFFFF, 6'd0, "R5");
    run(64'h8000000000000000, 6'd0, "R7");
    run(64'd42, 6'b000011, "R6");
    run(64'd987654321, 6'b100000, "R8");
    for (int i = 0; i < 6; i++)
      run({$urandom, $urandom} % LIM, 6'($urandom) & 6'b111110, "R8");
    @(negedge clk);
    cur_req = "R10"; start = 1'b1; bin_in = 64'd55; exc_in = 6'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; bin_in = 64'h8000000000000000; exc_in = 6'b000001;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT) @(negedge clk);
    cur_req = "R9";
    for (int i = 0; i < 8; i++) begin
      bin_in = {$urandom, $urandom}; exc_in = 6'($urandom);
      @(negedge clk);
    end
    run(64'd314159, 6'd0, "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule